// File: doc/BRIEF.md
# SPI Ring-Buffer Target

This block is the peripheral side of a full-duplex SPI link (mode 0, MSB first). While the host holds chip select low, every byte it clocks in is stored in a circular input buffer. In the same clock cycles, the byte at the same position of a circular output buffer is shifted back out. One pointer indexes both buffers, so the reply a local controller places at position N goes out in the same byte slot as the request byte that lands at position N.

A local controller reaches the block through a byte-wide port. With the top address bit clear, the port selects one of six registers. With the top address bit set, a write goes to the output buffer and a read returns the input buffer. The block sets event flags when the pointer crosses the half and the end of the buffer, when a programmable number of bytes has arrived since chip select fell, and on both chip-select edges. The controller can therefore drain input and refill output half a buffer at a time. All SPI pins are oversampled in the system clock domain, so the system clock must run at least eight times faster than SCLK.

Register map (index in address bits [2:0]): 0 control, 1 event status, 2 event mask, 3 level threshold, 4 pointer (read only), 5 status (read only).

Top module: `spi_ring_target`

## Requirements
- R1: MOSI is captured on each rising SCLK edge and MISO changes only after falling SCLK edges, most significant bit first. Bit 7 of the outgoing byte is present on MISO before the first rising edge after chip select falls. MISO is 0 while chip select is high.
- R2: One pointer (register 4, 0 to DEPTH) serves both buffers. Each completed byte is stored at input position `ptr`, the pointer then steps by one, and the next byte shifted out is output position `ptr`.
- R3: With control bit 2 (wrap) set, the pointer returns to 0 after position DEPTH-1. With it clear, the pointer stops at DEPTH, and later bytes are neither stored nor counted.
- R4: Event bit 0 sets when a byte is stored at position DEPTH/2-1, and event bit 1 sets when a byte is stored at position DEPTH-1.
- R5: Event bit 2 sets when the number of bytes received since chip select fell equals the level field (register 3 bits [AW-1:0]), provided the level is non-zero and the lock bit (register 3 bit 7) is clear.
- R6: A write to register 3 always updates the lock bit. It updates the level field only if the lock bit was already set before the write. Register 3 resets to lock 1, level 0.
- R7: Event bit 3 sets on a chip-select falling edge. Event bit 4 sets on a rising edge even when no SCLK pulse occurred. Event bit 5 sets on a rising edge only if at least one rising SCLK edge occurred while chip select was low.
- R8: Status bit 0 (register 5) reads 1 while the block is enabled and chip select is low.
- R9: Writing 1 to an event bit clears it. A set event in the same cycle wins over the clear. While control bit 0 (enable) is 0, the event status, pointer and shifter stay cleared and no event sets.
- R10: With control bit 1 (host write enable) clear, received bytes do not change the input buffer, but the pointer still advances.
- R11: `irq` is high exactly when some event bit is set whose mask bit (register 2) is set.
- R12: After reset the control, event status, event mask and pointer read 0, status reads 0, register 3 reads 0x80, and `miso` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCLK |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | SPI serial clock from the host |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| bus_we | input | 1 | Local write strobe |
| bus_addr | input | AW+1 | Local address; top bit selects buffer space |
| bus_wdata | input | 8 | Local write data |
| bus_rdata | output | 8 | Local read data (combinational) |
| irq | output | 1 | Masked event request |

## Verification
The main data path is driven with a vector table of host bytes that covers all-zeros, all-ones, alternating bit patterns and single-bit values. Each byte position has a distinct output pattern, so a swapped bit order, a wrong sampling edge or a pointer that is off by one shows up as a different MISO or stored byte. Long runs that cross the half point and the end of the buffer, first with wrap on and then with wrap off, tell the two end-of-buffer behaviours apart. Short chip-select pulses with no clocks separate the two rising-edge events. Runs with host write disabled and with the block disabled separate "pointer moves but nothing is stored" from "nothing happens at all".

// File: rtl/spi_ring_pkg.sv
// Shared constants for the SPI ring-buffer target: register indices and
// event bit positions. Assumes an 8-bit local data path.
package spi_ring_pkg;
    localparam int NUM_EV = 6;

    localparam logic [2:0] REG_CTRL   = 3'd0;
    localparam logic [2:0] REG_EVSTAT = 3'd1;
    localparam logic [2:0] REG_EVMASK = 3'd2;
    localparam logic [2:0] REG_LEVEL  = 3'd3;
    localparam logic [2:0] REG_PTR    = 3'd4;
    localparam logic [2:0] REG_STATUS = 3'd5;

    localparam int EV_HALF   = 0;
    localparam int EV_FULL   = 1;
    localparam int EV_LEVEL  = 2;
    localparam int EV_CSFALL = 3;
    localparam int EV_CSRISE = 4;
    localparam int EV_EOR    = 5;
endpackage

// File: rtl/spi_ring_sync.sv
// Two-flop synchronizer with edge detection for a vector of asynchronous
// pins. Assumes each pin holds a level for at least three system clocks.
module spi_ring_sync #(
    parameter int         W    = 3,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] q,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1, s2, s3;
        // Resynchronize one pin and keep its previous value for edges.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1 <= INIT[i];
                s2 <= INIT[i];
                s3 <= INIT[i];
            end else begin
                s1 <= din[i];
                s2 <= s1;
                s3 <= s2;
            end
        end
        assign q[i]    = s2;
        assign rise[i] = s2 & ~s3;
        assign fall[i] = ~s2 & s3;
    end
endmodule

// File: rtl/spi_ring_shifter.sv
// Bit engine for SPI mode 0: assembles incoming bytes on rising SCLK and
// shifts the outgoing byte on falling SCLK. Pulses byte_done one cycle
// after the eighth rising edge. Assumes synchronized single-cycle edges.
module spi_ring_shifter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       active,
    input  logic       cs_start,
    input  logic       sclk_rise,
    input  logic       sclk_fall,
    input  logic       mosi_s,
    input  logic [7:0] tx_byte,
    output logic [7:0] rx_byte,
    output logic       byte_done,
    output logic       tx_bit,
    output logic       clk_seen
);
    logic [2:0] bitcnt;
    logic [7:0] tx_sr;

    // Shift registers, bit counter and clock-seen flag for one window.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            bitcnt    <= '0;
            rx_byte   <= '0;
            tx_sr     <= '0;
            byte_done <= 1'b0;
            clk_seen  <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (cs_start) begin
                bitcnt   <= '0;
                tx_sr    <= tx_byte;
                clk_seen <= 1'b0;
            end else if (active) begin
                if (sclk_rise) begin
                    rx_byte  <= {rx_byte[6:0], mosi_s};
                    bitcnt   <= bitcnt + 3'd1;
                    clk_seen <= 1'b1;
                    if (bitcnt == 3'd7) begin
                        byte_done <= 1'b1;
                    end
                end else if (sclk_fall && clk_seen) begin
                    if (bitcnt == 3'd0) begin
                        tx_sr <= tx_byte;
                    end else begin
                        tx_sr <= {tx_sr[6:0], 1'b0};
                    end
                end
            end
        end
    end

    assign tx_bit = tx_sr[7];
endmodule

// File: rtl/spi_ring_regs.sv
// Control, event-status, mask and level-threshold registers. Event bits
// are write-1-to-clear with set priority; all events clear while disabled.
module spi_ring_regs
    import spi_ring_pkg::*;
#(
    parameter int LW = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [7:0]        wr_data,
    input  logic [NUM_EV-1:0] ev_set,
    output logic              en,
    output logic              hwen,
    output logic              wrap,
    output logic [NUM_EV-1:0] evstat,
    output logic [NUM_EV-1:0] evmask,
    output logic [LW-1:0]     lvl,
    output logic              lvl_dis
);
    logic [NUM_EV-1:0] ev_next;

    // Control bits: enable, host write enable, wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {wrap, hwen, en} <= '0;
        end else if (wr_en && wr_sel == REG_CTRL) begin
            {wrap, hwen, en} <= wr_data[2:0];
        end
    end

    // Event mask register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evmask <= '0;
        end else if (wr_en && wr_sel == REG_EVMASK) begin
            evmask <= wr_data[NUM_EV-1:0];
        end
    end

    // Level threshold: field changes only while the lock was already set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl     <= '0;
            lvl_dis <= 1'b1;
        end else if (wr_en && wr_sel == REG_LEVEL) begin
            lvl_dis <= wr_data[7];
            if (lvl_dis) begin
                lvl <= wr_data[LW-1:0];
            end
        end
    end

    // Next event status: set wins over write-1-to-clear.
    always_comb begin
        ev_next = evstat;
        for (int i = 0; i < NUM_EV; i++) begin
            if (ev_set[i]) begin
                ev_next[i] = 1'b1;
            end else if (wr_en && wr_sel == REG_EVSTAT && wr_data[i]) begin
                ev_next[i] = 1'b0;
            end
        end
    end

    // Event status register, held clear while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            evstat <= '0;
        end else begin
            evstat <= ev_next;
        end
    end
endmodule

// File: rtl/spi_ring_target.sv
// Full-duplex SPI target with circular input and output buffers sharing one
// pointer. Raises half, full, level and chip-select events for a local
// controller. Assumes 8 <= DEPTH <= 128, DEPTH a power of two, and a system
// clock at least eight times faster than SCLK.
module spi_ring_target
    import spi_ring_pkg::*;
#(
    parameter  int DEPTH = 128,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sclk,
    input  logic        cs_n,
    input  logic        mosi,
    output logic        miso,
    input  logic        bus_we,
    input  logic [AW:0] bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        irq
);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
    localparam logic [AW-1:0] HALF_IDX = AW'(DEPTH / 2 - 1);

    logic [2:0] pin_q, pin_rise, pin_fall;
    logic       cs_low, cs_fall, cs_rise, sclk_rise, sclk_fall;
    logic [1:0] unused_edges;

    logic              en, hwen, wrap, lvl_dis, busy, active;
    logic [NUM_EV-1:0] evstat, evmask, ev_set;
    logic [AW-1:0]     lvl;
    logic [AW:0]       ptr, xcnt, xcnt_inc;
    logic [AW-1:0]     ptr_idx;
    logic              at_end, byte_done, clk_seen, tx_bit, store, step;
    logic [7:0]        rx_byte, tx_byte;

    logic [7:0] ibuf [DEPTH];
    logic [7:0] obuf [DEPTH];

    spi_ring_sync #(.W(3), .INIT(3'b010)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({sclk, cs_n, mosi}),
        .q    (pin_q),
        .rise (pin_rise),
        .fall (pin_fall)
    );

    assign cs_low       = ~pin_q[1];
    assign cs_fall      = pin_fall[1];
    assign cs_rise      = pin_rise[1];
    assign sclk_rise    = pin_rise[2];
    assign sclk_fall    = pin_fall[2];
    assign unused_edges = {pin_rise[0], pin_fall[0]};

    assign active  = en & cs_low;
    assign busy    = active;
    assign ptr_idx = ptr[AW-1:0];
    assign at_end  = ptr[AW];
    assign tx_byte = obuf[ptr_idx];

    spi_ring_shifter u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .active   (active),
        .cs_start (en & cs_fall),
        .sclk_rise(sclk_rise),
        .sclk_fall(sclk_fall),
        .mosi_s   (pin_q[0]),
        .tx_byte  (tx_byte),
        .rx_byte  (rx_byte),
        .byte_done(byte_done),
        .tx_bit   (tx_bit),
        .clk_seen (clk_seen)
    );

    assign miso     = active & tx_bit;
    assign step     = byte_done & en & ~at_end;
    assign store    = step & hwen;
    assign xcnt_inc = xcnt + (AW + 1)'(1);

    // Shared pointer: steps per byte, wraps or parks at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            ptr <= '0;
        end else if (step) begin
            if (wrap && ptr_idx == LAST_IDX) begin
                ptr <= '0;
            end else begin
                ptr <= ptr + (AW + 1)'(1);
            end
        end
    end

    // Bytes received since chip select fell, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || cs_fall) begin
            xcnt <= '0;
        end else if (byte_done && xcnt != '1) begin
            xcnt <= xcnt_inc;
        end
    end

    // Input buffer write from the SPI side.
    always_ff @(posedge clk) begin
        if (store) begin
            ibuf[ptr_idx] <= rx_byte;
        end
    end

    // Output buffer write from the local side.
    always_ff @(posedge clk) begin
        if (bus_we && bus_addr[AW]) begin
            obuf[bus_addr[AW-1:0]] <= bus_wdata;
        end
    end

    // Event set conditions.
    always_comb begin
        ev_set            = '0;
        ev_set[EV_HALF]   = step && ptr_idx == HALF_IDX;
        ev_set[EV_FULL]   = step && ptr_idx == LAST_IDX;
        ev_set[EV_LEVEL]  = en && byte_done && !lvl_dis && lvl != '0
                            && xcnt_inc == {1'b0, lvl};
        ev_set[EV_CSFALL] = en && cs_fall;
        ev_set[EV_CSRISE] = en && cs_rise;
        ev_set[EV_EOR]    = en && cs_rise && clk_seen;
    end

    spi_ring_regs #(.LW(AW)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bus_we & ~bus_addr[AW]),
        .wr_sel (bus_addr[2:0]),
        .wr_data(bus_wdata),
        .ev_set (ev_set),
        .en     (en),
        .hwen   (hwen),
        .wrap   (wrap),
        .evstat (evstat),
        .evmask (evmask),
        .lvl    (lvl),
        .lvl_dis(lvl_dis)
    );

    // Local read mux: registers or input buffer.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr[AW]) begin
            bus_rdata = ibuf[bus_addr[AW-1:0]];
        end else begin
            case (bus_addr[2:0])
                REG_CTRL:   bus_rdata[2:0] = {wrap, hwen, en};
                REG_EVSTAT: bus_rdata[NUM_EV-1:0] = evstat;
                REG_EVMASK: bus_rdata[NUM_EV-1:0] = evmask;
                REG_LEVEL: begin
                    bus_rdata[7]      = lvl_dis;
                    bus_rdata[AW-1:0] = lvl;
                end
                REG_PTR:    bus_rdata[AW:0] = ptr;
                REG_STATUS: bus_rdata[0] = busy;
                default:    bus_rdata = '0;
            endcase
        end
    end

    assign irq = |(evstat & evmask);
endmodule

// File: rtl/spi_ring_target_chk.sv
// Property checker for spi_ring_target, attached by bind. Observes the
// pointer, event status, level lock and busy state.
module spi_ring_target_chk #(
    parameter  int DEPTH = 128,
    localparam int AW    = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic [AW:0]   ptr,
    input logic [5:0]    evstat,
    input logic [AW-1:0] lvl,
    input logic          lvl_dis,
    input logic          busy
);
    localparam logic [AW:0] PTR_MAX = (AW + 1)'(DEPTH);

    assert_clear_on_disable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (ptr == '0 && evstat == '0));

    assert_ptr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr != $past(ptr)) |-> (ptr == $past(ptr) + (AW + 1)'(1) || ptr == '0));

    assert_ptr_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= PTR_MAX);

    assert_event_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|evstat) |-> $past(en));

    assert_level_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl != $past(lvl)) |-> $past(lvl_dis));

    assert_busy_enabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> en);
endmodule

bind spi_ring_target spi_ring_target_chk #(.DEPTH(DEPTH)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en),
    .ptr    (ptr),
    .evstat (evstat),
    .lvl    (lvl),
    .lvl_dis(lvl_dis),
    .busy   (busy)
);

// File: tb/spi_ring_target_tb_top.sv
module spi_ring_target_tb_top;
    localparam int DEPTH = 128;
    localparam int AW    = 7;
    localparam int HP    = 6;

    // {mosi byte, expected miso byte}; output buffer holds i*7+3.
    localparam logic [15:0] VEC [8] = '{
        16'h0003, 16'hFF0A, 16'hA511, 16'h5A18,
        16'h011F, 16'h8026, 16'h3C2D, 16'hC334
    };

    localparam logic [7:0] A_CTRL = 8'h00, A_EV = 8'h01, A_MASK = 8'h02,
                           A_LVL = 8'h03, A_PTR = 8'h04, A_STAT = 8'h05;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, miso;
    logic bus_we = 1'b0, irq;
    logic [AW:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0, bus_rdata;
    int n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;

    spi_ring_target #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
        for (int b = 7; b >= 0; b--) begin
            @(negedge clk);
            mosi = tx[b];
            tick(HP);
            rx[b] = miso;
            sclk = 1'b1;
            tick(HP);
            sclk = 1'b0;
        end
        tick(2);
    endtask

    task automatic send_n(input int n, input logic [7:0] base);
        logic [7:0] dummy;
        for (int j = 0; j < n; j++) spi_byte(base ^ 8'(j), dummy);
    endtask

    task automatic cs_begin();
        @(negedge clk); cs_n = 1'b0; tick(8);
    endtask

    task automatic cs_end();
        tick(HP); cs_n = 1'b1; tick(8);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: R12 run hung, actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] d, rx;
        tick(4);
        rst_n = 1'b1;
        tick(2);

        // R12: reset state
        rd(A_CTRL, d); check("R12 ctrl", d, 8'h00);
        rd(A_EV, d);   check("R12 evstat", d, 8'h00);
        rd(A_PTR, d);  check("R12 ptr", d, 8'h00);
        rd(A_STAT, d); check("R12 status", d, 8'h00);
        rd(A_LVL, d);  check("R12 level", d, 8'h80);
        check("R12 miso", miso, 1'b0);
        check("R12 irq", irq, 1'b0);

        // Preload output buffer with i*7+3
        for (int i = 0; i < DEPTH; i++) wr(8'h80 | 8'(i), 8'(i * 7 + 3));
        wr(A_CTRL, 8'h07);

        // R1 / R2: table-driven full-duplex transfer
        cs_begin();
        rd(A_STAT, d); check("R8 busy while cs low", d, 8'h01);
        for (int k = 0; k < 8; k++) begin
            spi_byte(VEC[k][15:8], rx);
            check("R1 miso byte", rx, VEC[k][7:0]);
        end
        cs_end();
        rd(A_STAT, d); check("R8 idle after cs high", d, 8'h00);
        check("R1 miso idle", miso, 1'b0);
        for (int k = 0; k < 8; k++) begin
            rd(8'h80 | 8'(k), d);
            check("R2 stored byte", d, VEC[k][15:8]);
        end
        rd(A_PTR, d); check("R2 pointer after 8 bytes", d, 8'd8);
        rd(A_EV, d);  check("R7 fall/rise/eor events", d, 8'h38);

        // R9: write-1-to-clear of a single bit
        wr(A_EV, 8'h08);
        rd(A_EV, d); check("R9 w1c single bit", d, 8'h30);
        wr(A_EV, 8'h30);

        // R7 / R11: chip-select pulse without clocks
        wr(A_MASK, 8'h10);
        cs_begin(); cs_end();
        rd(A_EV, d); check("R7 rise without clocks, no eor", d, 8'h18);
        check("R11 irq on masked event", irq, 1'b1);
        wr(A_EV, 8'h3F);
        tick(1);
        check("R11 irq after clear", irq, 1'b0);
        wr(A_MASK, 8'h00);

        // R6: level lock
        wr(A_LVL, 8'h83);
        wr(A_LVL, 8'h03);
        rd(A_LVL, d); check("R6 level written under lock", d, 8'h03);
        wr(A_LVL, 8'h05);
        rd(A_LVL, d); check("R6 level ignored when unlocked", d, 8'h03);

        // R5: level event after third byte of a transaction
        cs_begin();
        send_n(2, 8'h11);
        rd(A_EV, d); check("R5 level not yet", d[2], 1'b0);
        send_n(1, 8'h22);
        rd(A_EV, d); check("R5 level reached", d[2], 1'b1);
        cs_end();
        wr(A_EV, 8'h3F);

        // R4 / R3: half, full and wrap (pointer now 11)
        cs_begin();
        send_n(52, 8'h40);
        rd(A_EV, d); check("R4 half not yet", d[0], 1'b0);
        send_n(1, 8'h40);
        rd(A_EV, d); check("R4 half event", d[0], 1'b1);
        rd(A_PTR, d); check("R4 pointer at half", d, 8'd64);
        send_n(63, 8'h40);
        rd(A_EV, d); check("R4 full not yet", d[1], 1'b0);
        send_n(1, 8'h40);
        rd(A_EV, d); check("R4 full event", d[1], 1'b1);
        rd(A_PTR, d); check("R3 wrap to zero", d, 8'd0);
        cs_end();

        // R9: disable clears status and pointer
        wr(A_CTRL, 8'h00);
        rd(A_EV, d);  check("R9 status cleared", d, 8'h00);
        rd(A_PTR, d); check("R9 pointer cleared", d, 8'h00);

        // R3: no wrap, pointer parks at DEPTH
        wr(A_CTRL, 8'h03);
        cs_begin();
        send_n(DEPTH, 8'h55);
        rd(A_PTR, d); check("R3 pointer parks", d, 8'h80);
        send_n(1, 8'hEE);
        rd(A_PTR, d); check("R3 pointer stays", d, 8'h80);
        cs_end();
        rd(8'hFF, d); check("R3 last byte kept", d, 8'h2A);
        rd(8'h80, d); check("R3 first byte not overwritten", d, 8'h55);

        // R10: host write disabled
        wr(A_CTRL, 8'h00);
        wr(A_CTRL, 8'h01);
        cs_begin();
        spi_byte(8'h99, rx);
        cs_end();
        rd(A_PTR, d); check("R10 pointer advances", d, 8'h01);
        rd(8'h80, d); check("R10 buffer unchanged", d, 8'h55);

        // R9: no events while disabled
        wr(A_CTRL, 8'h00);
        cs_begin(); cs_end();
        rd(A_EV, d);   check("R9 no events when disabled", d, 8'h00);
        rd(A_STAT, d); check("R8 busy needs enable", d, 8'h00);

        summary();
        $finish;
    end
endmodule